// File: doc/BRIEF.md
# Receive Frame Buffer Packer

This block takes one incoming Ethernet frame and stores it as a byte image in a fixed-size packet page. The frame arrives as a byte stream. Its length, the target page number and a page-granted flag are presented together on a single start strobe. The block first checks that the stored image would fit the page and that the receiver may accept frames at all. It then writes the image through a memory write port, one byte per cycle, at consecutive offsets from zero.

The stored image begins with a four-byte header. The header carries a status word (odd-length and over-length flags) and the total stored byte count, both little-endian. The payload follows, zero-padded to the minimum frame size when the frame is short. When CRC stripping is off, a running CRC-32 follows. The image ends with a two-byte control trailer. A frame of 64 bytes or more with an odd length keeps its last byte back and places it in the trailer, after the CRC, with a 0x60 marker. Every other frame ends with 0x00 and 0x40.

Page allocation and queueing live outside the block. The block reports completion with a done pulse carrying the stored byte count, and keeps a sticky receive interrupt that is cleared by an acknowledge input.

Top module: `rx_frame_packer`

## Requirements
- R1: Image bytes 0 and 1 hold the status word, low byte first. Bit 0x1000 is set for an odd frame length and bit 0x0800 for a length above 1518; every other bit is zero. Bytes 2 and 3 hold the stored byte count, low byte first.
- R2: The padded length is 64 for frames under 64 bytes, and otherwise the frame length with bit 0 cleared. The stored byte count is the padded length plus 6, plus 4 more when stripCrc is 0.
- R3: The padded-length bytes starting at offset 4 are the frame bytes in arrival order. For a frame under 64 bytes, zeros follow up to the padded length.
- R4: When stripCrc is 0, the CRC-32 is written least significant byte first at offset 4 plus the padded length. It uses the reflected polynomial 0xEDB88320, an all-ones preset and a final inversion. It covers every frame byte followed by any pad zeros.
- R5: The last two image bytes are the frame's final byte then 0x60 when the length is odd and at least 64. In every other case they are 0x00 then 0x40.
- R6: A start is rejected if the byte count would exceed 2048, if rxEnable is 0, if softReset is 1, or if pageOk is 0. A rejected start gives a one-cycle dropped pulse the cycle after it, no memory write and no done.
- R7: An accepted frame writes exactly byte-count bytes, one per write cycle. Offsets run 0,1,2,… within the given page, and memAddr is {pageNum, offset}.
- R8: In the cycle after the final trailer write, done pulses for one cycle and doneLen equals the byte count. rxIrq goes to 1 at the same time and stays 1 until irqAck is 1.
- R9: While a frame is being packed, startReady is 0 and startValid is ignored; the image in progress is unchanged.
- R10: After reset: startReady is 1, and inReady, memWe, done, dropped and rxIrq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enabled |
| softReset | input | 1 | Receiver held in soft reset (frames rejected) |
| stripCrc | input | 1 | 1: store no CRC |
| startValid | input | 1 | Frame start strobe |
| startReady | output | 1 | Idle; a start is taken this cycle |
| frameLen | input | LEN_W | Frame length in bytes |
| pageNum | input | PAGE_W | Target page |
| pageOk | input | 1 | A page was granted for this frame |
| inValid | input | 1 | Frame byte valid |
| inReady | output | 1 | Frame byte accepted this cycle |
| inByte | input | 8 | Frame byte |
| memWe | output | 1 | Page memory write enable |
| memAddr | output | PAGE_W+OFF_W | Page memory address {page, offset} |
| memData | output | 8 | Page memory write data |
| done | output | 1 | Frame stored (one-cycle pulse) |
| doneLen | output | LEN_W+1 | Stored byte count, valid with done |
| dropped | output | 1 | Frame rejected (one-cycle pulse) |
| rxIrq | output | 1 | Sticky receive interrupt |
| irqAck | input | 1 | Clears rxIrq |

## Verification
A wrong byte counter or a wrong phase sequence shifts every later byte. Within one frame this shows up as a bad CRC, a trailer at the wrong offset, or a write count that differs from doneLen. A corrupted CRC register only appears at the four CRC bytes near the end of the image, so each frame is compared byte for byte against an image built independently. Acceptance errors show at once: a missing dropped pulse, or memory writes in the cycles just after a start that should have been rejected.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_HDR, SEL_DATA, SEL_PAD, SEL_CRC, SEL_TAIL
  } byteSel_e;

  typedef enum logic [2:0] {
    PK_IDLE, PK_HDR, PK_BODY, PK_ODD, PK_CRC, PK_TAIL
  } pkState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;     // latch frame parameters, clear offset, preset CRC
    logic     write;    // a byte goes to memory this cycle
    logic     crcUpd;   // fold the current byte into the CRC
    logic     holdOdd;  // keep the current stream byte for the trailer
    byteSel_e sel;
    logic [1:0] idx;
  } ctlStrobe_t;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'b0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/rx_pack_datapath.sv
module rx_pack_datapath
  import rx_pack_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int PAGE_W     = 2,
  parameter int LEN_W      = 12,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int SZ_W      = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        st,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              stripCrc,
  input  logic [7:0]        inByte,
  output logic              fitsLive,
  output logic [SZ_W-1:0]   padLen,
  output logic [SZ_W-1:0]   srcLen,
  output logic              tailOdd,
  output logic              keepCrc,
  output logic [SZ_W-1:0]   byteCount,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [7:0]        memData
);

  function automatic logic [SZ_W-1:0] padOf(input logic [LEN_W-1:0] l);
    return (l < LEN_W'(64)) ? SZ_W'(64) : {1'b0, l[LEN_W-1:1], 1'b0};
  endfunction

  function automatic logic [SZ_W-1:0] sizeOf(input logic [LEN_W-1:0] l, input logic s);
    return padOf(l) + SZ_W'(6) + (s ? SZ_W'(0) : SZ_W'(4));
  endfunction

  logic [LEN_W-1:0]  lenQ;
  logic              stripQ;
  logic [PAGE_W-1:0] pageQ;
  logic [31:0]       crcQ;
  logic [7:0]        oddQ;
  logic [OFF_W-1:0]  offQ;
  logic              tooLong;
  logic [31:0]       crcOut;
  logic [7:0]        crcIn;

  assign fitsLive  = sizeOf(frameLen, stripCrc) <= SZ_W'(PAGE_BYTES);
  assign padLen    = padOf(lenQ);
  assign srcLen    = (lenQ < LEN_W'(64)) ? {1'b0, lenQ} : padOf(lenQ);
  assign tailOdd   = lenQ[0] && (lenQ >= LEN_W'(64));
  assign keepCrc   = !stripQ;
  assign byteCount = sizeOf(lenQ, stripQ);
  assign tooLong   = lenQ > LEN_W'(1518);
  assign crcOut    = ~crcQ;
  assign crcIn     = (st.sel == SEL_PAD) ? 8'h00 : inByte;
  assign memAddr   = {pageQ, offQ};

  always_comb begin
    memData = 8'h00;
    case (st.sel)
      SEL_HDR: begin
        case (st.idx)
          2'd0:    memData = 8'h00;
          2'd1:    memData = {3'b000, lenQ[0], tooLong, 3'b000};
          2'd2:    memData = byteCount[7:0];
          default: memData = 8'(byteCount >> 8);
        endcase
      end
      SEL_DATA: memData = inByte;
      SEL_CRC:  memData = crcOut[st.idx*8 +: 8];
      SEL_TAIL: memData = (st.idx == 2'd0) ? (tailOdd ? oddQ : 8'h00)
                                           : (tailOdd ? 8'h60 : 8'h40);
      default:  memData = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenQ <= '0; stripQ <= 1'b0; pageQ <= '0;
      crcQ <= '1; oddQ <= 8'h00; offQ <= '0;
    end else begin
      if (st.load) begin
        lenQ <= frameLen; stripQ <= stripCrc; pageQ <= pageNum;
        crcQ <= '1; offQ <= '0;
      end else begin
        if (st.write)   offQ <= offQ + OFF_W'(1);
        if (st.crcUpd)  crcQ <= crcByte(crcQ, crcIn);
        if (st.holdOdd) oddQ <= inByte;
      end
    end
  end

  AST_HDR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st.write && st.sel == SEL_HDR && st.idx == 2'd0) |-> offQ == '0); // R7
  AST_TAIL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st.write && st.sel == SEL_TAIL && st.idx == 2'd1) |-> offQ == OFF_W'(byteCount - SZ_W'(1))); // R7

endmodule

// File: rtl/rx_pack_ctrl.sv
module rx_pack_ctrl
  import rx_pack_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int LEN_W      = 12,
  localparam int SZ_W      = LEN_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            startValid,
  input  logic            rxEnable,
  input  logic            softReset,
  input  logic            pageOk,
  input  logic            fitsLive,
  input  logic            inValid,
  input  logic [SZ_W-1:0] padLen,
  input  logic [SZ_W-1:0] srcLen,
  input  logic            tailOdd,
  input  logic            keepCrc,
  input  logic [SZ_W-1:0] byteCount,
  input  logic            irqAck,
  output ctlStrobe_t      st,
  output logic            startReady,
  output logic            inReady,
  output logic            memWe,
  output logic            done,
  output logic            dropped,
  output logic            rxIrq
);

  pkState_e        stQ, stD;
  logic [SZ_W-1:0] posQ, posD;
  logic [1:0]      idxQ, idxD;
  logic            doneQ, dropQ, irqQ;
  logic            finish, reject, step;

  always_comb begin
    st = '0; stD = stQ; posD = posQ; idxD = idxQ;
    finish = 1'b0; reject = 1'b0; step = 1'b0; inReady = 1'b0;
    case (stQ)
      PK_IDLE: if (startValid) begin
        if (rxEnable && !softReset && pageOk && fitsLive) begin
          st.load = 1'b1; stD = PK_HDR; idxD = 2'd0; posD = '0;
        end else reject = 1'b1;
      end
      PK_HDR: begin
        st.write = 1'b1; st.sel = SEL_HDR; st.idx = idxQ;
        idxD = idxQ + 2'd1;
        if (idxQ == 2'd3) stD = PK_BODY;
      end
      PK_BODY: begin
        if (posQ < srcLen) begin
          st.sel = SEL_DATA; inReady = 1'b1; step = inValid;
        end else begin
          st.sel = SEL_PAD; step = 1'b1;
        end
        st.write = step; st.crcUpd = step;
        if (step) begin
          posD = posQ + SZ_W'(1);
          if (posQ == padLen - SZ_W'(1)) begin
            stD = tailOdd ? PK_ODD : (keepCrc ? PK_CRC : PK_TAIL);
            idxD = 2'd0;
          end
        end
      end
      PK_ODD: begin
        st.sel = SEL_DATA; inReady = 1'b1;
        st.holdOdd = inValid; st.crcUpd = inValid;
        if (inValid) stD = keepCrc ? PK_CRC : PK_TAIL;
      end
      PK_CRC: begin
        st.write = 1'b1; st.sel = SEL_CRC; st.idx = idxQ;
        idxD = idxQ + 2'd1;
        if (idxQ == 2'd3) stD = PK_TAIL;
      end
      PK_TAIL: begin
        st.write = 1'b1; st.sel = SEL_TAIL; st.idx = idxQ;
        idxD = idxQ + 2'd1;
        if (idxQ == 2'd1) begin stD = PK_IDLE; finish = 1'b1; idxD = 2'd0; end
      end
      default: stD = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ <= PK_IDLE; posQ <= '0; idxQ <= 2'd0;
      doneQ <= 1'b0; dropQ <= 1'b0; irqQ <= 1'b0;
    end else begin
      stQ <= stD; posQ <= posD; idxQ <= idxD;
      doneQ <= finish;
      dropQ <= reject;
      irqQ  <= finish | (irqQ & ~irqAck);
    end
  end

  assign startReady = (stQ == PK_IDLE);
  assign memWe      = st.write;
  assign done       = doneQ;
  assign dropped    = dropQ;
  assign rxIrq      = irqQ;

  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> !startReady); // R9
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |-> (!memWe && !done)); // R6
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rxIrq); // R8
  AST_DONE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> byteCount <= SZ_W'(PAGE_BYTES)); // R6

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rx_pack_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int PAGE_W     = 2,
  parameter int LEN_W      = 12,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int SZ_W      = LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rxEnable,
  input  logic                    softReset,
  input  logic                    stripCrc,
  input  logic                    startValid,
  output logic                    startReady,
  input  logic [LEN_W-1:0]        frameLen,
  input  logic [PAGE_W-1:0]       pageNum,
  input  logic                    pageOk,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [7:0]              inByte,
  output logic                    memWe,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [7:0]              memData,
  output logic                    done,
  output logic [SZ_W-1:0]         doneLen,
  output logic                    dropped,
  output logic                    rxIrq,
  input  logic                    irqAck
);

  ctlStrobe_t      st;
  logic            fitsLive, tailOdd, keepCrc;
  logic [SZ_W-1:0] padLen, srcLen, byteCount;

  rx_pack_ctrl #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .rxEnable(rxEnable),
    .softReset(softReset), .pageOk(pageOk), .fitsLive(fitsLive), .inValid(inValid),
    .padLen(padLen), .srcLen(srcLen), .tailOdd(tailOdd), .keepCrc(keepCrc),
    .byteCount(byteCount), .irqAck(irqAck), .st(st), .startReady(startReady),
    .inReady(inReady), .memWe(memWe), .done(done), .dropped(dropped), .rxIrq(rxIrq)
  );

  rx_pack_datapath #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .frameLen(frameLen), .pageNum(pageNum),
    .stripCrc(stripCrc), .inByte(inByte), .fitsLive(fitsLive), .padLen(padLen),
    .srcLen(srcLen), .tailOdd(tailOdd), .keepCrc(keepCrc), .byteCount(byteCount),
    .memAddr(memAddr), .memData(memData)
  );

  assign doneLen = byteCount;

endmodule

// File: tb/rx_frame_packer_tb_top.sv
`timescale 1ns/1ps
module rx_frame_packer_tb_top;

  localparam int PAGE_BYTES = 2048;
  localparam int PAGE_W = 2;
  localparam int LEN_W = 12;
  localparam int OFF_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxEnable = 1'b0, softReset = 1'b0, stripCrc = 1'b0, startValid = 1'b0;
  logic startReady, inReady, memWe, done, dropped, rxIrq;
  logic [LEN_W-1:0] frameLen = '0;
  logic [PAGE_W-1:0] pageNum = '0;
  logic pageOk = 1'b0, inValid = 1'b0, irqAck = 1'b0;
  logic [7:0] inByte = 8'h00, memData;
  logic [PAGE_W+OFF_W-1:0] memAddr;
  logic [LEN_W:0] doneLen;

  always #5 clk = ~clk;

  rx_frame_packer dut_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .softReset(softReset),
    .stripCrc(stripCrc), .startValid(startValid), .startReady(startReady),
    .frameLen(frameLen), .pageNum(pageNum), .pageOk(pageOk), .inValid(inValid),
    .inReady(inReady), .inByte(inByte), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .done(done), .doneLen(doneLen), .dropped(dropped),
    .rxIrq(rxIrq), .irqAck(irqAck)
  );

  int nChk = 0, nFail = 0;
  logic [7:0] fbuf [0:4095];
  logic [7:0] expB [0:PAGE_BYTES-1];
  logic [7:0] got  [0:PAGE_BYTES-1];
  int gotCnt = 0, addrErr = 0, curPage = 0, doneLenSeen = 0;
  bit doneSeen = 0, dropSeen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: sample well after the negedge, when the driver is settled.
  always begin
    @(negedge clk); #2;
    if (memWe) begin
      if (int'(memAddr[PAGE_W+OFF_W-1:OFF_W]) != curPage ||
          int'(memAddr[OFF_W-1:0]) != gotCnt) addrErr++;
      if (gotCnt < PAGE_BYTES) got[gotCnt] = memData;
      gotCnt++;
    end
    if (done) begin doneSeen = 1; doneLenSeen = int'(doneLen); end
    if (dropped) dropSeen = 1;
  end

  task automatic cmpRegion(input int lo, input int n, input string req, input string what);
    int bad = 0, fa = 0, fe = 0;
    for (int i = lo; i < lo + n; i++)
      if (got[i] !== expB[i]) begin
        if (bad == 0) begin fa = int'(got[i]); fe = int'(expB[i]); end
        bad++;
      end
    chk(bad == 0, req, what, fa, fe);
  endtask

  task automatic runFrame(input int len, input bit strip, input int page, input bit en,
                          input bit srst, input bit pok, input int seed, input bit midStart,
                          input string name);
    int pad, cnt, idx, guard, status;
    bit expDrop, tOdd;
    logic [31:0] c;
    for (int i = 0; i < len; i++) fbuf[i] = 8'((seed + i * 37 + (i >> 3)) & 255);
    pad = (len < 64) ? 64 : (len & ~1);
    cnt = pad + 6 + (strip ? 0 : 4);
    expDrop = !en || srst || !pok || cnt > PAGE_BYTES;
    tOdd = (len % 2 == 1) && len >= 64;
    if (!expDrop) begin
      status = ((len % 2) ? 32'h1000 : 0) | ((len > 1518) ? 32'h0800 : 0);
      expB[0] = 8'(status); expB[1] = 8'(status >> 8);
      expB[2] = 8'(cnt);    expB[3] = 8'(cnt >> 8);
      for (int i = 0; i < pad; i++) expB[4 + i] = (i < len) ? fbuf[i] : 8'h00;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < ((len < 64) ? 64 : len); i++) begin
        c = c ^ {24'b0, ((i < len) ? fbuf[i] : 8'h00)};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      if (!strip) for (int k = 0; k < 4; k++) expB[4 + pad + k] = 8'(c >> (8 * k));
      expB[cnt - 2] = tOdd ? fbuf[len - 1] : 8'h00;
      expB[cnt - 1] = tOdd ? 8'h60 : 8'h40;
    end
    gotCnt = 0; addrErr = 0; doneSeen = 0; dropSeen = 0; curPage = page;
    @(negedge clk);
    rxEnable = en; softReset = srst; stripCrc = strip; pageOk = pok;
    frameLen = LEN_W'(len); pageNum = PAGE_W'(page); startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    idx = 0; guard = 0;
    while (!doneSeen && !dropSeen && guard < 8000) begin
      inValid = (idx < len) && (guard % 5 != 4);
      inByte  = (idx < len) ? fbuf[idx] : 8'h00;
      if (midStart && guard == 20) begin
        startValid = 1'b1; frameLen = LEN_W'(300); pageNum = PAGE_W'(page + 1);
      end else startValid = 1'b0;
      #1;
      if (inValid && inReady) idx++;
      @(negedge clk); guard++;
    end
    inValid = 1'b0; startValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(guard < 8000, "R7", {name, " finished in time"}, guard, 8000);
    if (expDrop) begin
      chk(dropSeen, "R6", {name, " dropped pulse"}, dropSeen, 1);
      chk(gotCnt == 0, "R6", {name, " no writes"}, gotCnt, 0);
      chk(!doneSeen, "R6", {name, " no done"}, doneSeen, 0);
    end else begin
      if (midStart) chk(!dropSeen, "R9", {name, " mid-frame start ignored"}, dropSeen, 0);
      chk(doneSeen && doneLenSeen == cnt, "R8", {name, " doneLen"}, doneLenSeen, cnt);
      chk(doneLenSeen == cnt, "R2", {name, " byte count"}, doneLenSeen, cnt);
      chk(gotCnt == cnt, "R7", {name, " write count"}, gotCnt, cnt);
      chk(addrErr == 0, "R7", {name, " address sequence"}, addrErr, 0);
      if (gotCnt == cnt) begin
        cmpRegion(0, 4, "R1", {name, " header"});
        cmpRegion(4, pad, "R3", {name, " payload"});
        if (!strip) cmpRegion(4 + pad, 4, "R4", {name, " crc"});
        cmpRegion(cnt - 2, 2, "R5", {name, " trailer"});
      end
      chk(rxIrq == 1'b1, "R8", {name, " irq set"}, rxIrq, 1);
    end
  endtask

  task automatic ackIrq();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    #2 chk(rxIrq == 1'b0, "R8", "irq cleared by ack", rxIrq, 0);
  endtask

  task automatic checkReset();
    #2;
    chk(startReady == 1'b1, "R10", "startReady after reset", startReady, 1);
    chk(!inReady && !memWe, "R10", "no stream or write after reset", {inReady, memWe}, 0);
    chk(!done && !dropped && !rxIrq, "R10", "no done/drop/irq after reset",
        {done, dropped, rxIrq}, 0);
  endtask

  initial begin
    #1500000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk + 1, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkReset();
    runFrame(100,  1'b0, 1, 1, 0, 1, 11, 0, "even crc");
    ackIrq();
    runFrame(101,  1'b0, 2, 1, 0, 1, 23, 0, "odd crc");
    runFrame(33,   1'b1, 3, 1, 0, 1, 5,  0, "short odd strip");
    runFrame(60,   1'b0, 0, 1, 0, 1, 77, 0, "short even crc");
    runFrame(64,   1'b1, 1, 1, 0, 1, 91, 0, "min size strip");
    runFrame(1600, 1'b0, 2, 1, 0, 1, 3,  0, "over-length");
    runFrame(2039, 1'b0, 3, 1, 0, 1, 40, 0, "fits exactly odd");
    runFrame(2042, 1'b1, 0, 1, 0, 1, 17, 0, "fits exactly strip");
    runFrame(2040, 1'b0, 1, 1, 0, 1, 9,  0, "too big crc");
    runFrame(2044, 1'b1, 1, 1, 0, 1, 9,  0, "too big strip");
    runFrame(80,   1'b0, 2, 0, 0, 1, 9,  0, "rx disabled");
    runFrame(80,   1'b0, 2, 1, 1, 1, 9,  0, "soft reset");
    runFrame(80,   1'b0, 2, 1, 0, 0, 9,  0, "no page");
    runFrame(120,  1'b1, 1, 1, 0, 1, 55, 1, "start while busy");
    ackIrq();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule